// File: doc/BRIEF.md
# Host and Global Reset Arbiter

This block gathers reset requests from many sources, grouped by the kind of reset each source asks for, and decides which reset the platform carries out: a host reset without a power cycle (warm), a host reset with a power cycle (cold), a global reset with a power cycle, or a forced move into soft-off with the system held there. The choice depends on the current sleep state and on whether software put the system into that state.

Warm and cold host resets are normally preceded by a warning handshake with the processor. The block raises a warning and waits up to a programmable number of cycles for an acknowledge. A management-engine request for a host reset with power down also waits for an enabled wake event after the acknowledge. If that request gets no acknowledge, it escalates to a global reset. Global and soft-off requests bypass the handshake and take effect at once, pre-empting any handshake in progress. Each reset leaves a one-cycle pulse on its own output, and a cause register keeps the class of the last action.

Top module: `rst_arbiter`

## Requirements
- R1: In S0 (sleep code 0), a warm request raises `warn_o` in the next cycle. When `ack_i` is sampled high during the warning, `rst_warm_o` pulses for one cycle in the following cycle, `warn_o` drops, and `pwr_down_o` stays low.
- R2: A warm request that arrives while the sleep code is 1, 2 or 3 (S3, S4, S5) is discarded. No warning and no pulse follow, and `cause_o` keeps its value.
- R3: A cold request that arrives in a sleep state with `sw_sleep_i` high skips the warning. `rst_cold_o` and `pwr_down_o` pulse in the cycle after the request. In S0, a cold request runs the warning handshake first.
- R4: A global request pulses `rst_global_o` and `pwr_down_o` in the cycle after it arrives, with no warning. If a handshake is in progress, the global request aborts it, and the abandoned request never fires.
- R5: A soft-off request sets `stay_off_o` and pulses `pwr_down_o` in the next cycle. While `stay_off_o` is high, `warn_o` stays low, no request produces any pulse, and `stay_off_o` clears only on `rst_ni`.
- R6: When requests arrive in the same cycle, the most severe one wins, in the order soft-off, global, cold (including the management-engine request), warm. The losers are dropped.
- R7: `warn_o` stays high for at most `ack_limit_i` consecutive cycles, and a limit of 0 acts as 1. For warm and cold requests, reaching that limit without an acknowledge fires the requested reset anyway.
- R8: For a management-engine power-down request, an acknowledge leads to a wait for `wake_done_i`. The cycle after `wake_done_i` is sampled high, `rst_cold_o` and `pwr_down_o` pulse. In a software-entered sleep state, the warning is skipped and the wait starts at once.
- R9: If a management-engine power-down request reaches the acknowledge limit, `rst_global_o` and `pwr_down_o` pulse instead.
- R10: At most one of `rst_warm_o`, `rst_cold_o` and `rst_global_o` is high in any cycle, and `pwr_down_o` accompanies every cold or global pulse.
- R11: `cause_o` is updated with the reset pulse and encodes the last action as follows: 0 none, 1 warm, 2 cold, 3 global, 4 soft-off, 5 escalated global.
- R12: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| warm_req_i | input | N_WARM | Warm host reset request pulses |
| cold_req_i | input | N_COLD | Cold host reset request pulses |
| me_pd_req_i | input | 1 | Management-engine host reset with power down request |
| glob_req_i | input | N_GLOB | Global reset request pulses |
| off_req_i | input | N_OFF | Go-to-soft-off request pulses |
| sleep_state_i | input | 2 | Sleep state: 0 S0, 1 S3, 2 S4, 3 S5 |
| sw_sleep_i | input | 1 | Current sleep state was entered by software |
| wake_done_i | input | 1 | Enabled wake event completed |
| ack_i | input | 1 | Processor acknowledge of the warning |
| ack_limit_i | input | CNT_W | Maximum warning length in cycles |
| warn_o | output | 1 | Reset warning to the processor |
| rst_warm_o | output | 1 | Warm host reset pulse |
| rst_cold_o | output | 1 | Cold host reset pulse |
| rst_global_o | output | 1 | Global reset pulse |
| pwr_down_o | output | 1 | Power-down request pulse |
| stay_off_o | output | 1 | Held in soft-off |
| cause_o | output | 3 | Class of the last action |

## Verification
Each request class is driven on its own in S0 and in sleep states with and without the software flag. This separates dropping, skipping the warning and running the handshake. Each handshake is closed three ways: by an acknowledge, by letting the limit expire, and by a global request arriving mid-warning. This tells normal completion, timeout completion, escalation and pre-emption apart. Simultaneous multi-class requests show that the severity order is honoured. Requests sent after soft-off show the hold.

// File: rtl/rst_arb_pkg.sv
package rst_arb_pkg;

   typedef enum logic [2:0] {
      CLS_NONE,
      CLS_WARM,
      CLS_COLD,
      CLS_ME,
      CLS_GLOBAL,
      CLS_OFF
   } cls_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_WARN,
      ST_WAKE,
      ST_OFF
   } st_e;

   localparam logic [2:0] CAUSE_NONE   = 3'd0;
   localparam logic [2:0] CAUSE_WARM   = 3'd1;
   localparam logic [2:0] CAUSE_COLD   = 3'd2;
   localparam logic [2:0] CAUSE_GLOBAL = 3'd3;
   localparam logic [2:0] CAUSE_OFF    = 3'd4;
   localparam logic [2:0] CAUSE_ESC    = 3'd5;

   localparam logic [1:0] SLP_S0 = 2'd0;

endpackage

// File: rtl/rst_arb_any.sv
module rst_arb_any #(
   parameter int W = 2
) (
   input  logic [W-1:0] req_i,
   output logic         any_o
);
   generate
      if (W == 1) begin : g_single
         assign any_o = req_i[0];
      end else begin : g_multi
         assign any_o = |req_i;
      end
   endgenerate
endmodule

// File: rtl/rst_arb_prio.sv
module rst_arb_prio
   import rst_arb_pkg::*;
#(
   parameter bit ME_OVER_COLD = 1'b0
) (
   input  logic off_i,
   input  logic glob_i,
   input  logic cold_i,
   input  logic me_i,
   input  logic warm_i,
   output cls_e win_o
);
   cls_e mid_cls;
   logic mid_any;

   assign mid_any = cold_i | me_i;

   generate
      if (ME_OVER_COLD) begin : g_me_first
         assign mid_cls = me_i ? CLS_ME : CLS_COLD;
      end else begin : g_cold_first
         assign mid_cls = cold_i ? CLS_COLD : CLS_ME;
      end
   endgenerate

   always_comb begin
      if (off_i)        win_o = CLS_OFF;
      else if (glob_i)  win_o = CLS_GLOBAL;
      else if (mid_any) win_o = mid_cls;
      else if (warm_i)  win_o = CLS_WARM;
      else              win_o = CLS_NONE;
   end
endmodule

// File: rtl/rst_arb_ack_timer.sv
module rst_arb_ack_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             start_i,
   input  logic             run_i,
   input  logic [CNT_W-1:0] limit_i,
   output logic             tc_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         cnt_q <= '0;
      else if (start_i)                    cnt_q <= '0;
      else if (run_i && cnt_q != CNT_MAX)  cnt_q <= cnt_q + 1'b1;
   end

   assign tc_o = ({1'b0, cnt_q} + 1'b1) >= {1'b0, limit_i};
endmodule

// File: rtl/rst_arbiter.sv
module rst_arbiter
   import rst_arb_pkg::*;
#(
   parameter int N_WARM       = 2,
   parameter int N_COLD       = 2,
   parameter int N_GLOB       = 2,
   parameter int N_OFF        = 3,
   parameter int CNT_W        = 8,
   parameter bit ME_OVER_COLD = 1'b0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [N_WARM-1:0] warm_req_i,
   input  logic [N_COLD-1:0] cold_req_i,
   input  logic              me_pd_req_i,
   input  logic [N_GLOB-1:0] glob_req_i,
   input  logic [N_OFF-1:0]  off_req_i,
   input  logic [1:0]        sleep_state_i,
   input  logic              sw_sleep_i,
   input  logic              wake_done_i,
   input  logic              ack_i,
   input  logic [CNT_W-1:0]  ack_limit_i,
   output logic              warn_o,
   output logic              rst_warm_o,
   output logic              rst_cold_o,
   output logic              rst_global_o,
   output logic              pwr_down_o,
   output logic              stay_off_o,
   output logic [2:0]        cause_o
);

   generate
      if (N_WARM < 1 || N_COLD < 1 || N_GLOB < 1 || N_OFF < 1) begin : g_bad_src
         $error("every request group needs at least one source");
      end
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt
         $error("CNT_W must lie in 2..32");
      end
   endgenerate

   logic any_warm, any_cold, any_glob, any_off;
   cls_e win;

   rst_arb_any #(.W(N_WARM)) u_any_warm (.req_i(warm_req_i), .any_o(any_warm));
   rst_arb_any #(.W(N_COLD)) u_any_cold (.req_i(cold_req_i), .any_o(any_cold));
   rst_arb_any #(.W(N_GLOB)) u_any_glob (.req_i(glob_req_i), .any_o(any_glob));
   rst_arb_any #(.W(N_OFF))  u_any_off  (.req_i(off_req_i),  .any_o(any_off));

   rst_arb_prio #(.ME_OVER_COLD(ME_OVER_COLD)) u_prio (
      .off_i  (any_off),
      .glob_i (any_glob),
      .cold_i (any_cold),
      .me_i   (me_pd_req_i),
      .warm_i (any_warm),
      .win_o  (win)
   );

   st_e        st_q, st_d;
   cls_e       pend_q, pend_d;
   logic [2:0] cause_q, cause_d;
   logic       stay_q, stay_d;
   logic       warm_q, warm_d, cold_q, cold_d, glob_q, glob_d, pd_q, pd_d;
   logic       tmr_start, tmr_tc, sleeping, skip_warn;

   rst_arb_ack_timer #(.CNT_W(CNT_W)) u_timer (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (tmr_start),
      .run_i   (st_q == ST_WARN),
      .limit_i (ack_limit_i),
      .tc_o    (tmr_tc)
   );

   assign sleeping  = (sleep_state_i != SLP_S0);
   assign skip_warn = sleeping & sw_sleep_i;

   always_comb begin
      st_d      = st_q;
      pend_d    = pend_q;
      cause_d   = cause_q;
      stay_d    = stay_q;
      warm_d    = 1'b0;
      cold_d    = 1'b0;
      glob_d    = 1'b0;
      pd_d      = 1'b0;
      tmr_start = 1'b0;
      if (st_q != ST_OFF && win == CLS_OFF) begin
         st_d    = ST_OFF;
         stay_d  = 1'b1;
         pd_d    = 1'b1;
         cause_d = CAUSE_OFF;
      end else if (st_q != ST_OFF && win == CLS_GLOBAL) begin
         st_d    = ST_IDLE;
         glob_d  = 1'b1;
         pd_d    = 1'b1;
         cause_d = CAUSE_GLOBAL;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               unique case (win)
                  CLS_COLD: begin
                     if (skip_warn) begin
                        cold_d  = 1'b1;
                        pd_d    = 1'b1;
                        cause_d = CAUSE_COLD;
                     end else begin
                        st_d      = ST_WARN;
                        pend_d    = CLS_COLD;
                        tmr_start = 1'b1;
                     end
                  end
                  CLS_ME: begin
                     pend_d    = CLS_ME;
                     tmr_start = 1'b1;
                     st_d      = skip_warn ? ST_WAKE : ST_WARN;
                  end
                  CLS_WARM: begin
                     if (!sleeping) begin
                        st_d      = ST_WARN;
                        pend_d    = CLS_WARM;
                        tmr_start = 1'b1;
                     end
                  end
                  default: ;
               endcase
            end
            ST_WARN: begin
               if (ack_i || tmr_tc) begin
                  st_d = ST_IDLE;
                  if (pend_q == CLS_ME) begin
                     if (ack_i) begin
                        st_d = ST_WAKE;
                     end else begin
                        glob_d  = 1'b1;
                        pd_d    = 1'b1;
                        cause_d = CAUSE_ESC;
                     end
                  end else if (pend_q == CLS_WARM) begin
                     warm_d  = 1'b1;
                     cause_d = CAUSE_WARM;
                  end else begin
                     cold_d  = 1'b1;
                     pd_d    = 1'b1;
                     cause_d = CAUSE_COLD;
                  end
               end
            end
            ST_WAKE: begin
               if (wake_done_i) begin
                  st_d    = ST_IDLE;
                  cold_d  = 1'b1;
                  pd_d    = 1'b1;
                  cause_d = CAUSE_COLD;
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q    <= ST_IDLE;
         pend_q  <= CLS_NONE;
         cause_q <= CAUSE_NONE;
         stay_q  <= 1'b0;
         warm_q  <= 1'b0;
         cold_q  <= 1'b0;
         glob_q  <= 1'b0;
         pd_q    <= 1'b0;
      end else begin
         st_q    <= st_d;
         pend_q  <= pend_d;
         cause_q <= cause_d;
         stay_q  <= stay_d;
         warm_q  <= warm_d;
         cold_q  <= cold_d;
         glob_q  <= glob_d;
         pd_q    <= pd_d;
      end
   end

   assign warn_o       = (st_q == ST_WARN);
   assign rst_warm_o   = warm_q;
   assign rst_cold_o   = cold_q;
   assign rst_global_o = glob_q;
   assign pwr_down_o   = pd_q;
   assign stay_off_o   = stay_q;
   assign cause_o      = cause_q;

endmodule

// File: rtl/rst_arbiter_chk.sv
module rst_arbiter_chk #(
   parameter int CNT_W = 8
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic [CNT_W-1:0] ack_limit_i,
   input logic             warn_o,
   input logic             rst_warm_o,
   input logic             rst_cold_o,
   input logic             rst_global_o,
   input logic             pwr_down_o,
   input logic             stay_off_o
);
   logic [CNT_W:0] warn_run;
   logic [CNT_W:0] lim_eff;

   assign lim_eff = (ack_limit_i == '0) ? {{CNT_W{1'b0}}, 1'b1} : {1'b0, ack_limit_i};

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     warn_run <= '0;
      else if (warn_o) warn_run <= warn_run + 1'b1;
      else             warn_run <= '0;
   end

   a_r10_one_class: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({rst_warm_o, rst_cold_o, rst_global_o}));

   a_r10_pwrdn_with_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rst_cold_o || rst_global_o) |-> pwr_down_o);

   a_r1_warm_after_warn: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rst_warm_o |-> $past(warn_o));

   a_r5_stay_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stay_off_o |=> stay_off_o);

   a_r5_off_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(stay_off_o) |-> !(warn_o || rst_warm_o || rst_cold_o || rst_global_o || pwr_down_o));

   a_r7_warn_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
      warn_o |-> (warn_run < lim_eff));
endmodule

bind rst_arbiter rst_arbiter_chk #(.CNT_W(CNT_W)) chk_i (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .ack_limit_i  (ack_limit_i),
   .warn_o       (warn_o),
   .rst_warm_o   (rst_warm_o),
   .rst_cold_o   (rst_cold_o),
   .rst_global_o (rst_global_o),
   .pwr_down_o   (pwr_down_o),
   .stay_off_o   (stay_off_o)
);

// File: tb/rst_arbiter_tb.sv
module rst_arbiter_tb_top;
   localparam int CNT_W = 8;
   localparam int LIM   = 6;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [1:0]       warm_req = '0;
   logic [1:0]       cold_req = '0;
   logic             me_req = 1'b0;
   logic [1:0]       glob_req = '0;
   logic [2:0]       off_req = '0;
   logic [1:0]       sleep_st = 2'd0;
   logic             sw_sleep = 1'b0;
   logic             wake = 1'b0;
   logic             ack = 1'b0;
   logic [CNT_W-1:0] limit = CNT_W'(LIM);
   logic             warn, r_warm, r_cold, r_glob, pd, stay;
   logic [2:0]       cause;

   int errors = 0;
   int checks = 0;

   always #10 clk = ~clk;

   rst_arbiter #(.N_WARM(2), .N_COLD(2), .N_GLOB(2), .N_OFF(3), .CNT_W(CNT_W)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .warm_req_i(warm_req), .cold_req_i(cold_req),
      .me_pd_req_i(me_req), .glob_req_i(glob_req), .off_req_i(off_req),
      .sleep_state_i(sleep_st), .sw_sleep_i(sw_sleep), .wake_done_i(wake),
      .ack_i(ack), .ack_limit_i(limit), .warn_o(warn), .rst_warm_o(r_warm),
      .rst_cold_o(r_cold), .rst_global_o(r_glob), .pwr_down_o(pd),
      .stay_off_o(stay), .cause_o(cause)
   );

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // outputs packed as {warn, warm, cold, global, pwr_down, stay}
   function automatic int outs();
      return {26'd0, warn, r_warm, r_cold, r_glob, pd, stay};
   endfunction

   task automatic do_reset();
      rst_n = 1'b0;
      tick();
      tick();
      rst_n = 1'b1;
      tick();
   endtask

   task automatic clear_in();
      warm_req = '0; cold_req = '0; me_req = 0; glob_req = '0; off_req = '0;
      ack = 0; wake = 0; sleep_st = 2'd0; sw_sleep = 0; limit = CNT_W'(LIM);
   endtask

   task automatic t_reset();
      chk("R12 outputs after reset", outs(), 0);
      chk("R12 cause after reset", cause, 0);
   endtask

   task automatic t_warm_ack();
      clear_in();
      warm_req = 2'b10;
      tick();
      warm_req = '0;
      chk("R1 warning raised", outs(), 6'b100000);
      tick();
      tick();
      ack = 1;
      tick();
      ack = 0;
      chk("R1 warm pulse after ack", outs(), 6'b010000);
      chk("R11 cause warm", cause, 1);
      tick();
      chk("R1 warm pulse single cycle", outs(), 0);
   endtask

   task automatic t_warm_drop();
      for (int s = 1; s < 4; s++) begin
         clear_in();
         sleep_st = 2'(s);
         warm_req = 2'b01;
         tick();
         warm_req = '0;
         for (int i = 0; i < 4; i++) begin
            chk("R2 warm dropped in sleep", outs(), 0);
            tick();
         end
         chk("R2 cause unchanged", cause, 1);
      end
   endtask

   task automatic t_warm_timeout();
      clear_in();
      warm_req = 2'b01;
      tick();
      warm_req = '0;
      for (int i = 0; i < LIM; i++) begin
         chk("R7 warning held until limit", outs(), 6'b100000);
         tick();
      end
      chk("R7 warm fires at limit", outs(), 6'b010000);
      tick();
   endtask

   task automatic t_limit_zero();
      clear_in();
      limit = '0;
      warm_req = 2'b01;
      tick();
      warm_req = '0;
      chk("R7 limit zero one warning cycle", outs(), 6'b100000);
      tick();
      chk("R7 limit zero fires", outs(), 6'b010000);
      tick();
      limit = CNT_W'(LIM);
   endtask

   task automatic t_cold();
      clear_in();
      sleep_st = 2'd2;
      sw_sleep = 1;
      cold_req = 2'b01;
      tick();
      cold_req = '0;
      chk("R3 cold skip warning", outs(), 6'b001010);
      chk("R11 cause cold", cause, 2);
      tick();
      chk("R3 cold single cycle", outs(), 0);
      clear_in();
      cold_req = 2'b10;
      tick();
      cold_req = '0;
      chk("R3 cold warns in S0", outs(), 6'b100000);
      ack = 1;
      tick();
      ack = 0;
      chk("R3 cold after ack", outs(), 6'b001010);
      tick();
   endtask

   task automatic t_global();
      clear_in();
      glob_req = 2'b10;
      tick();
      glob_req = '0;
      chk("R4 global immediate", outs(), 6'b000110);
      chk("R11 cause global", cause, 3);
      tick();
      warm_req = 2'b01;
      tick();
      warm_req = '0;
      chk("R4 warning before preempt", outs(), 6'b100000);
      glob_req = 2'b01;
      tick();
      glob_req = '0;
      chk("R4 global preempts warning", outs(), 6'b000110);
      for (int i = 0; i < LIM + 2; i++) begin
         tick();
         chk("R4 abandoned warm never fires", outs(), 0);
      end
   endtask

   task automatic t_priority();
      clear_in();
      warm_req = 2'b11;
      cold_req = 2'b01;
      glob_req = 2'b01;
      tick();
      clear_in();
      chk("R6 global beats cold and warm", outs(), 6'b000110);
      tick();
      chk("R6 losers dropped", outs(), 0);
      cold_req = 2'b01;
      warm_req = 2'b01;
      sleep_st = 2'd3;
      sw_sleep = 1;
      tick();
      clear_in();
      chk("R6 cold beats warm", outs(), 6'b001010);
      tick();
   endtask

   task automatic t_me_ack();
      clear_in();
      me_req = 1;
      tick();
      me_req = 0;
      chk("R8 me warning", outs(), 6'b100000);
      ack = 1;
      tick();
      ack = 0;
      for (int i = 0; i < 3; i++) begin
         chk("R8 waiting for wake", outs(), 0);
         tick();
      end
      wake = 1;
      tick();
      wake = 0;
      chk("R8 cold after wake", outs(), 6'b001010);
      chk("R8 cause cold", cause, 2);
      tick();
      sleep_st = 2'd3;
      sw_sleep = 1;
      me_req = 1;
      tick();
      me_req = 0;
      chk("R8 sleep skip warning", outs(), 0);
      wake = 1;
      tick();
      wake = 0;
      chk("R8 sleep cold after wake", outs(), 6'b001010);
      tick();
   endtask

   task automatic t_me_escalate();
      clear_in();
      me_req = 1;
      tick();
      me_req = 0;
      for (int i = 0; i < LIM; i++) begin
         chk("R9 me warning until limit", outs(), 6'b100000);
         tick();
      end
      chk("R9 escalated global", outs(), 6'b000110);
      chk("R11 cause escalated", cause, 5);
      tick();
   endtask

   task automatic t_soft_off();
      clear_in();
      off_req = 3'b100;
      glob_req = 2'b01;
      tick();
      clear_in();
      chk("R6 soft-off beats global", outs(), 6'b000011);
      chk("R11 cause soft-off", cause, 4);
      glob_req = 2'b01;
      warm_req = 2'b01;
      cold_req = 2'b01;
      tick();
      clear_in();
      for (int i = 0; i < 3; i++) begin
         chk("R5 held in soft-off", outs(), 6'b000001);
         tick();
      end
      do_reset();
      chk("R5 reset clears soft-off", outs(), 0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      do_reset();
      t_reset();
      t_warm_ack();
      t_warm_drop();
      t_warm_timeout();
      t_limit_zero();
      t_cold();
      t_global();
      t_priority();
      t_me_ack();
      t_me_escalate();
      t_soft_off();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule